// File: doc/BRIEF.md
# Bridge Power-State Register and Downstream Cycle Gate

This block holds the 32-bit power management control/status register of a PCI-to-PCI bridge function. It also turns the stored power state into claim or abort decisions for cycles headed downstream. Configuration requests arrive one at a time on a valid/ready request channel. Each request carries a byte offset, write data and byte enables. Every accepted request, read or write, produces one completion on a valid/ready response channel. A request is accepted only while no completion is waiting. A completion stays valid, with its data held, until the consumer takes it with `cfg_rsp_ready`. Offsets other than the register's own read as zero and ignore writes.

The register stores a two-bit power state and a sticky PME-enable bit. Every other bit returns a fixed value. Only the full-power state and the deepest low-power state can be stored. A write that asks for either of the two intermediate states still completes, but it changes nothing. The PME-enable bit is kept across a normal reset and is cleared only by a power-on reset. It drives no hardware.

Outside full power, the bridge refuses every downstream cycle except type 0 configuration. Each refused cycle raises a pulse for one cycle so that an external status bit can record the master abort. Permission flags for interrupts and memory-mapped accesses are raised only at full power.

Top module: `pm_state_gate`

## Requirements
- R1: After reset the register (byte offset 84h, dword at address bits 7:2 = 21h) reads 00000008h and the power state output is 00 (D0).
- R2: A write with byte enable 0 set and data bits 1:0 equal to 11 moves the state to D3. The same write with 00 returns it to D0. Encoding: 00 = D0, 01 = D1, 10 = D2, 11 = D3.
- R3: A write with data bits 1:0 equal to 01 or 10 still completes, but the stored state does not change. The stored state is never 01 or 10.
- R4: Bit 8 (PME enable) is written from data bit 8 when byte enable 1 is set. It keeps its value through `rst_n` and is cleared by `por_n`.
- R5: Bits 31:9 and 7:2 ignore writes. They always read as zero, except bit 3, which reads as one.
- R6: A cleared byte enable 0 leaves the power state unchanged. A cleared byte enable 1 leaves the PME-enable bit unchanged.
- R7: In D0 every downstream cycle is claimed and none is aborted.
- R8: Outside D0 only type 0 configuration cycles (kind 00) are claimed. Kinds 01 (type 1 configuration), 10 (memory) and 11 (I/O) raise `dn_abort` for exactly the cycle in which `dn_valid` is high. Claim and abort are never high together.
- R9: `irq_allow` and `mmio_allow` are high in D0 and low in D3.
- R10: `cfg_req_ready` is low while a completion is pending. A completion holds its data stable until it is taken. A request to any other offset reads zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves PME enable unchanged |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears everything |
| cfg_req_valid | input | 1 | Configuration request present |
| cfg_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cfg_req_write | input | 1 | 1 = write, 0 = read |
| cfg_req_addr | input | 8 | Configuration byte offset |
| cfg_req_wdata | input | 32 | Write data |
| cfg_req_be | input | 4 | Byte enables for the write |
| cfg_rsp_valid | output | 1 | Completion present |
| cfg_rsp_ready | input | 1 | Completion taken when high with valid |
| cfg_rsp_rdata | output | 32 | Read data (zero for writes) |
| dn_valid | input | 1 | Downstream cycle presented |
| dn_kind | input | 2 | 00 cfg type 0, 01 cfg type 1, 10 memory, 11 I/O |
| dn_claim | output | 1 | Cycle is claimed |
| dn_abort | output | 1 | One-cycle master-abort pulse |
| irq_allow | output | 1 | Interrupts permitted |
| mmio_allow | output | 1 | Memory-mapped register cycles permitted |
| power_state | output | 2 | Current stored power state |

## Verification
The register is written with all-ones data and full byte enables, with each unsupported state code, and with partial byte-enable masks. These patterns separate the read-only bits, the write filter and the per-byte update paths from one another. All four cycle kinds are presented in D0 and again in D3, which shows that only the type 0 configuration kind escapes gating. A normal reset and a power-on reset are each applied with PME enable set, which separates the sticky bit from the power state. A completion is held back for several cycles to check that the request channel stalls and the read data stays stable.

// File: rtl/pm_state_pkg.sv
package pm_state_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    CYC_CFG0 = 2'b00,
    CYC_CFG1 = 2'b01,
    CYC_MEM  = 2'b10,
    CYC_IO   = 2'b11
  } cyc_kind_e;

  function automatic logic state_supported(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3);
  endfunction
endpackage

// File: rtl/pm_state_regs.sv
module pm_state_regs
  import pm_state_pkg::*;
#(
  parameter logic [5:0] LOW_RO_BITS = 6'b000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output pstate_e           ps,
  output logic [DATA_W-1:0] value
);
  localparam int PME_BIT = 8;

  pstate_e ps_q;
  logic    pme_q;
  logic    ps_rst_n;

  assign ps_rst_n = rst_n & por_n;

  always_ff @(posedge clk or negedge ps_rst_n) begin
    if (!ps_rst_n) begin
      ps_q <= PS_D0;
    end else if (wr_en && be[0] && state_supported(wdata[1:0])) begin
      ps_q <= pstate_e'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pme_q <= 1'b0;
    end else if (wr_en && be[1]) begin
      pme_q <= wdata[PME_BIT];
    end
  end

  always_comb begin
    value          = '0;
    value[1:0]     = ps_q;
    value[7:2]     = LOW_RO_BITS;
    value[PME_BIT] = pme_q;
  end

  assign ps = ps_q;

  p_ps_legal_r3: assert property (@(posedge clk) disable iff (!ps_rst_n)
    (ps_q == PS_D0) || (ps_q == PS_D3));

  p_ps_hold_r3: assert property (@(posedge clk) disable iff (!ps_rst_n)
    (wr_en && be[0] && !state_supported(wdata[1:0])) |=> $stable(ps_q));

  p_ps_be_r6: assert property (@(posedge clk) disable iff (!ps_rst_n)
    (wr_en && !be[0]) |=> $stable(ps_q));

  p_pme_be_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !be[1]) |=> $stable(pme_q));
endmodule

// File: rtl/pm_cycle_gate.sv
module pm_cycle_gate
  import pm_state_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pstate_e   ps,
  input  logic      dn_valid,
  input  cyc_kind_e dn_kind,
  output logic      dn_claim,
  output logic      dn_abort,
  output logic      irq_allow,
  output logic      mmio_allow
);
  logic full_power;

  assign full_power = (ps == PS_D0);
  assign dn_claim   = dn_valid && (full_power || dn_kind == CYC_CFG0);
  assign dn_abort   = dn_valid && !full_power && dn_kind != CYC_CFG0;
  assign irq_allow  = full_power;
  assign mmio_allow = full_power;

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_claim && dn_abort));

  p_cfg0_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_kind == CYC_CFG0) |-> dn_claim);

  p_abort_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_abort |-> dn_valid);

  p_d0_noabort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_D0) |-> !dn_abort);

  p_d3_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_D3) |-> (!irq_allow && !mmio_allow));
endmodule

// File: rtl/pm_state_gate.sv
module pm_state_gate
  import pm_state_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              cfg_req_valid,
  output logic              cfg_req_ready,
  input  logic              cfg_req_write,
  input  logic [ADDR_W-1:0] cfg_req_addr,
  input  logic [DATA_W-1:0] cfg_req_wdata,
  input  logic [BE_W-1:0]   cfg_req_be,
  output logic              cfg_rsp_valid,
  input  logic              cfg_rsp_ready,
  output logic [DATA_W-1:0] cfg_rsp_rdata,
  input  logic              dn_valid,
  input  logic [1:0]        dn_kind,
  output logic              dn_claim,
  output logic              dn_abort,
  output logic              irq_allow,
  output logic              mmio_allow,
  output logic [1:0]        power_state
);
  localparam int DW_LSB = 2;

  logic              rst_all_n;
  logic              accept;
  logic              hit;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] reg_value;
  pstate_e           ps;

  assign rst_all_n     = rst_n & por_n;
  assign cfg_req_ready = !rsp_valid_q;
  assign accept        = cfg_req_valid && cfg_req_ready;
  assign hit           = cfg_req_addr[ADDR_W-1:DW_LSB] == REG_OFFSET[ADDR_W-1:DW_LSB];

  pm_state_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .por_n (por_n),
    .wr_en (accept && cfg_req_write && hit),
    .wdata (cfg_req_wdata),
    .be    (cfg_req_be),
    .ps    (ps),
    .value (reg_value)
  );

  pm_cycle_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_all_n),
    .ps         (ps),
    .dn_valid   (dn_valid),
    .dn_kind    (cyc_kind_e'(dn_kind)),
    .dn_claim   (dn_claim),
    .dn_abort   (dn_abort),
    .irq_allow  (irq_allow),
    .mmio_allow (mmio_allow)
  );

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= (!cfg_req_write && hit) ? reg_value : '0;
    end else if (cfg_rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign cfg_rsp_valid = rsp_valid_q;
  assign cfg_rsp_rdata = rsp_data_q;
  assign power_state   = ps;

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_all_n)
    (cfg_rsp_valid && !cfg_rsp_ready) |=> (cfg_rsp_valid && $stable(cfg_rsp_rdata)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_all_n)
    cfg_rsp_valid |-> !cfg_req_ready);

  p_accept_rsp_r10: assert property (@(posedge clk) disable iff (!rst_all_n)
    (cfg_req_valid && cfg_req_ready) |=> cfg_rsp_valid);
endmodule

// File: tb/pm_state_gate_test.sv
module pm_state_gate_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write;
  logic [7:0]  cfg_req_addr;
  logic [31:0] cfg_req_wdata;
  logic [3:0]  cfg_req_be;
  logic        cfg_rsp_valid, cfg_rsp_ready;
  logic [31:0] cfg_rsp_rdata;
  logic        dn_valid;
  logic [1:0]  dn_kind;
  logic        dn_claim, dn_abort, irq_allow, mmio_allow;
  logic [1:0]  power_state;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_state_gate uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_addr(cfg_req_addr),
    .cfg_req_wdata(cfg_req_wdata), .cfg_req_be(cfg_req_be),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_ready(cfg_rsp_ready),
    .cfg_rsp_rdata(cfg_rsp_rdata),
    .dn_valid(dn_valid), .dn_kind(dn_kind),
    .dn_claim(dn_claim), .dn_abort(dn_abort),
    .irq_allow(irq_allow), .mmio_allow(mmio_allow),
    .power_state(power_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                        input logic [3:0] be, output logic [31:0] rdata);
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_write = wr; cfg_req_addr = addr;
    cfg_req_wdata = data; cfg_req_be = be;
    check("R10 ready idle", {31'b0, cfg_req_ready}, 32'd1);
    @(negedge clk);
    cfg_req_valid = 1'b0;
    check("R10 rsp valid", {31'b0, cfg_rsp_valid}, 32'd1);
    rdata = cfg_rsp_rdata;
    cfg_rsp_ready = 1'b1;
    @(negedge clk);
    cfg_rsp_ready = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] d);
    access(1'b0, addr, 32'h0, 4'h0, d);
  endtask

  task automatic wr(input logic [31:0] data, input logic [3:0] be);
    logic [31:0] d;
    access(1'b1, 8'h84, data, be, d);
  endtask

  task automatic cyc(input string req, input logic [1:0] kind, input logic exp_claim);
    @(negedge clk);
    dn_valid = 1'b1; dn_kind = kind;
    #1;
    check(req, {30'b0, dn_claim, dn_abort}, {30'b0, exp_claim, !exp_claim});
    @(negedge clk);
    dn_valid = 1'b0;
    #1;
    check({req, " no pulse when idle"}, {31'b0, dn_abort}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h84, d);
    check("R1 reset value", d, 32'h0000_0008);
    check("R1 reset state", {30'b0, power_state}, 32'd0);
  endtask

  task automatic t_d0_cycles;
    check("R9 irq/mmio in D0", {30'b0, irq_allow, mmio_allow}, 32'd3);
    for (int k = 0; k < 4; k++) cyc("R7 D0 claim", 2'(k), 1'b1);
  endtask

  task automatic t_write_all;
    logic [31:0] d;
    wr(32'hFFFF_FFFF, 4'hF);
    rd(8'h84, d);
    check("R5 R2 ro bits and D3", d, 32'h0000_010B);
    check("R2 state D3", {30'b0, power_state}, 32'd3);
    check("R9 irq/mmio in D3", {30'b0, irq_allow, mmio_allow}, 32'd0);
  endtask

  task automatic t_d3_cycles;
    cyc("R8 D3 cfg0", 2'b00, 1'b1);
    cyc("R8 D3 cfg1", 2'b01, 1'b0);
    cyc("R8 D3 mem",  2'b10, 1'b0);
    cyc("R8 D3 io",   2'b11, 1'b0);
  endtask

  task automatic t_unsupported;
    logic [31:0] d;
    wr(32'h0000_0101, 4'h1);
    rd(8'h84, d);
    check("R3 D1 write dropped", d, 32'h0000_010B);
    wr(32'h0000_0102, 4'h1);
    rd(8'h84, d);
    check("R3 D2 write dropped", d, 32'h0000_010B);
  endtask

  task automatic t_byte_enables;
    logic [31:0] d;
    wr(32'h0000_0000, 4'h2);
    rd(8'h84, d);
    check("R6 be1 only clears pme", d, 32'h0000_000B);
    wr(32'h0000_0100, 4'h1);
    rd(8'h84, d);
    check("R2 return to D0 via byte 0", d, 32'h0000_0008);
    wr(32'h0000_0103, 4'hE);
    rd(8'h84, d);
    check("R6 be0 clear keeps D0, R4 pme set", d, 32'h0000_0108);
  endtask

  task automatic t_other_offset;
    logic [31:0] d;
    access(1'b1, 8'h88, 32'hFFFF_FFFF, 4'hF, d);
    rd(8'h88, d);
    check("R10 other offset reads zero", d, 32'h0);
    rd(8'h84, d);
    check("R10 other offset write ignored", d, 32'h0000_0108);
  endtask

  task automatic t_backpressure;
    logic [31:0] d;
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_write = 1'b0; cfg_req_addr = 8'h84; cfg_req_be = 4'h0;
    @(negedge clk);
    cfg_req_valid = 1'b0;
    d = cfg_rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 rsp held", {31'b0, cfg_rsp_valid}, 32'd1);
      check("R10 req stalled", {31'b0, cfg_req_ready}, 32'd0);
      check("R10 data stable", cfg_rsp_rdata, d);
    end
    check("R10 held data", d, 32'h0000_0108);
    cfg_rsp_ready = 1'b1;
    @(negedge clk);
    cfg_rsp_ready = 1'b0;
    check("R10 rsp consumed", {31'b0, cfg_rsp_valid}, 32'd0);
  endtask

  task automatic t_resets;
    logic [31:0] d;
    wr(32'h0000_0103, 4'h3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h84, d);
    check("R4 pme sticky over rst_n, state D0", d, 32'h0000_0108);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(8'h84, d);
    check("R4 por clears pme", d, 32'h0000_0008);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    cfg_req_valid = 1'b0; cfg_req_write = 1'b0; cfg_req_addr = '0;
    cfg_req_wdata = '0; cfg_req_be = '0; cfg_rsp_ready = 1'b0;
    dn_valid = 1'b0; dn_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset();
    t_d0_cycles();
    t_write_all();
    t_d3_cycles();
    t_unsupported();
    t_byte_enables();
    t_d0_cycles();
    t_other_offset();
    t_backpressure();
    t_resets();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule